// File: doc/BRIEF.md
# Display Interrupt Control and Status Registers

This block is the small register file a virtual display adapter exposes to its driver. It holds the vertical-blank interrupt enable in a dedicated control register, apart from the interrupt status register, and gathers two interrupt causes into one level interrupt line. The two causes are the vertical-blank tick and the fence-acknowledge event. Because the enable lives apart from the status bits, and because status bits only clear where software writes a one, a driver that turns vblank on or off cannot wipe out a fence acknowledge that is still waiting to be serviced.

The block also offers a command-execute offset and a captured fence value. A write to the command-execute offset is forwarded as a one-cycle strobe together with the written word. The 64-bit fence value is latched on each fence-acknowledge event and read back as two 32-bit halves. Command processing and the display pipeline sit outside the block.

Top module: `disp_irq_regs`

## Requirements
- R1: While reset is held, and on the cycle after it is released, the control register reads 0, the status register reads 0, both fence words read 0, `irq` is low and `cmd_stb` is low.
- R2: Offset 8 is the control register. Only bit 0, the vblank enable, is stored. A read returns the stored bit in bit 0 and zeros in bits 31:1.
- R3: A `vblank_tick` sets status bit 0 (vblank pending) only while the stored enable is 1. With the enable at 0 the tick leaves the status unchanged.
- R4: Offset 16 is the status register: bit 0 is vblank pending and bit 1 is fence-ack pending, and bits 31:2 read 0. Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R5: Any write to the control register leaves both status bits unchanged. In particular it never drops a pending fence acknowledge.
- R6: `irq` equals (enable AND vblank pending) OR fence-ack pending. It follows every control write, status write and event in the same cycle that the registers take the change.
- R7: When a hardware event and a software clear of the same status bit fall in the same cycle, the bit ends up set.
- R8: A `fence_ack` pulse sets status bit 1 and latches `fence_value`. Offset 24 then reads bits 31:0 of the latched value, and offset 32 reads bits 63:32.
- R9: A write to offset 0 raises `cmd_stb` for exactly the next cycle, with `cmd_word` equal to the written word. It leaves the control and status registers unchanged.
- R10: Reads of any offset other than 8, 16, 24 or 32 return 0, and offset 0 also reads 0. Writes to offsets 24 and 32, or to unmapped offsets, change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (6) | Byte offset of the register being accessed |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational from the registers |
| vblank_tick | input | 1 | One-cycle pulse marking the vertical blank |
| fence_ack | input | 1 | One-cycle pulse marking a completed fence |
| fence_value | input | 2*DATA_W (64) | Fence value latched on `fence_ack` |
| cmd_stb | output | 1 | One-cycle strobe after a write to the command offset |
| cmd_word | output | DATA_W (32) | Word written to the command offset |
| irq | output | 1 | Level interrupt request |

## Verification
A write, tick or fence event presented in one cycle is taken at the next rising edge. From that edge the register reads and `irq` show the new state, because `irq` and `bus_rdata` are combinational from the registers. `cmd_stb` is registered and is high only in the cycle that follows the write edge. The bench drives every input on the falling edge. It samples one nanosecond after the next falling edge, which keeps each sample half a cycle away from the edge that changed the result. It checks the strobe in that cycle and again one cycle later, to confirm the strobe has dropped.

// File: rtl/disp_irq_pkg.sv
// Package: disp_irq_pkg
// Shared offsets, status bit positions and the decoded-select type for the
// display interrupt register block. Assumes byte offsets on an 8-byte stride.
package disp_irq_pkg;

    // Byte offsets; the driver relies on these exact values.
    localparam int OFS_EXEC = 0;
    localparam int OFS_CTRL = 8;
    localparam int OFS_STAT = 16;
    localparam int OFS_FLO  = 24;
    localparam int OFS_FHI  = 32;

    // Status bit positions.
    localparam int ST_VBLANK = 0;
    localparam int ST_FENCE  = 1;
    localparam int ST_BITS   = 2;

    // One-hot register select produced by the decoder.
    typedef struct packed {
        logic exec;
        logic ctrl;
        logic stat;
        logic flo;
        logic fhi;
    } reg_sel_t;

endpackage

// File: rtl/disp_irq_decode.sv
// Module: disp_irq_decode
// Compares the bus offset with each mapped register offset and produces a
// one-hot select. An offset that matches nothing gives an all-zero select.
// Assumes the offsets in the package fit within ADDR_W bits.
module disp_irq_decode
    import disp_irq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    // Full-width compare against every mapped offset.
    always_comb begin
        sel      = '0;
        sel.exec = (addr == ADDR_W'(OFS_EXEC));
        sel.ctrl = (addr == ADDR_W'(OFS_CTRL));
        sel.stat = (addr == ADDR_W'(OFS_STAT));
        sel.flo  = (addr == ADDR_W'(OFS_FLO));
        sel.fhi  = (addr == ADDR_W'(OFS_FHI));
    end

endmodule

// File: rtl/disp_irq_w1c_bit.sv
// Module: disp_irq_w1c_bit
// A single sticky pending bit. A hardware set event wins over a software
// clear that falls in the same cycle. Assumes both inputs are synchronous
// to clk.
module disp_irq_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Hold, clear on request, and let a set override a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set | (q & ~clr);
    end

endmodule

// File: rtl/disp_irq_status.sv
// Module: disp_irq_status
// The interrupt status register, built from one sticky cell per cause.
// Bit i is set by set_i[i] and cleared by clr_i[i].
// Assumes the caller masks clr_i with the write strobe.
module disp_irq_status #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] pend_o
);

    // One independent sticky cell per cause.
    for (genvar i = 0; i < NUM; i++) begin : g_cell
        disp_irq_w1c_bit u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_i[i]),
            .clr   (clr_i[i]),
            .q     (pend_o[i])
        );
    end

endmodule

// File: rtl/disp_irq_fence_cap.sv
// Module: disp_irq_fence_cap
// Latches a wide fence value when capture is high and presents it as
// register-width words, with word 0 the least significant.
// Assumes FENCE_W is a whole multiple of WORD_W.
module disp_irq_fence_cap #(
    parameter int WORD_W  = 32,
    parameter int FENCE_W = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        capture,
    input  logic [FENCE_W-1:0]          value,
    output logic [FENCE_W/WORD_W-1:0][WORD_W-1:0] words
);

    localparam int NWORDS = FENCE_W / WORD_W;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        // Load this slice of the fence value on a capture event.
        always_ff @(posedge clk) begin
            if (!rst_n)       words[w] <= '0;
            else if (capture) words[w] <= value[w*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/disp_irq_regs.sv
// Module: disp_irq_regs (top)
// Register block for the display adapter's interrupt logic. It holds a
// control register with the vblank enable, a write-one-to-clear status
// register, a command strobe and the captured fence value, and drives a
// level interrupt. Assumes one bus access per cycle, reads that have no side
// effects, and single-cycle event pulses.
module disp_irq_regs
    import disp_irq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  vblank_tick,
    input  logic                  fence_ack,
    input  logic [2*DATA_W-1:0]   fence_value,
    output logic                  cmd_stb,
    output logic [DATA_W-1:0]     cmd_word,
    output logic                  irq
);

    localparam int FENCE_W = 2 * DATA_W;
    localparam int NWORDS  = FENCE_W / DATA_W;

    reg_sel_t                       sel;
    logic                           ctrl_en;
    logic [ST_BITS-1:0]             st_set;
    logic [ST_BITS-1:0]             st_clr;
    logic [ST_BITS-1:0]             st_pend;
    logic [NWORDS-1:0][DATA_W-1:0]  fence_words;

    disp_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Control register: only the vblank enable is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ctrl_en <= 1'b0;
        else if (bus_we && sel.ctrl)  ctrl_en <= bus_wdata[0];
    end

    // Status set and clear sources: events set, written ones clear.
    always_comb begin
        st_set            = '0;
        st_set[ST_VBLANK] = vblank_tick & ctrl_en;
        st_set[ST_FENCE]  = fence_ack;
        st_clr            = (bus_we && sel.stat) ? bus_wdata[ST_BITS-1:0] : '0;
    end

    disp_irq_status #(.NUM(ST_BITS)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (st_set),
        .clr_i  (st_clr),
        .pend_o (st_pend)
    );

    disp_irq_fence_cap #(.WORD_W(DATA_W), .FENCE_W(FENCE_W)) u_fence (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (fence_ack),
        .value   (fence_value),
        .words   (fence_words)
    );

    // Command strobe: one registered pulse carrying the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb  <= 1'b0;
            cmd_word <= '0;
        end else begin
            cmd_stb <= bus_we && sel.exec;
            if (bus_we && sel.exec) cmd_word <= bus_wdata;
        end
    end

    // Interrupt level: vblank gated by its enable, fence acknowledge ungated.
    always_comb begin
        irq = (ctrl_en & st_pend[ST_VBLANK]) | st_pend[ST_FENCE];
    end

    // Read mux: mapped readable registers, zero for everything else.
    always_comb begin
        bus_rdata = '0;
        if (sel.ctrl)      bus_rdata = DATA_W'(ctrl_en);
        else if (sel.stat) bus_rdata = DATA_W'(st_pend);
        else if (sel.flo)  bus_rdata = fence_words[0];
        else if (sel.fhi)  bus_rdata = fence_words[NWORDS-1];
    end

endmodule

// File: rtl/disp_irq_checker.sv
// Module: disp_irq_checker
// Temporal properties of disp_irq_regs, attached with bind below.
// Assumes the port and internal names of the top module.
module disp_irq_checker
    import disp_irq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 bus_we,
    input logic                 fence_ack,
    input logic [2*DATA_W-1:0]  fence_value,
    input logic                 cmd_stb,
    input logic [DATA_W-1:0]    cmd_word,
    input logic                 irq,
    input logic                 ctrl_en,
    input logic [1:0]           st_pend,
    input logic [2*DATA_W-1:0]  fence_q
);

    logic exec_wr;
    logic fence_clr_wr;
    assign exec_wr      = bus_we && (bus_addr == ADDR_W'(OFS_EXEC));
    assign fence_clr_wr = bus_we && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[1];

    // R1: nothing is asserted on the cycle after reset is released.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !cmd_stb));

    // R3: with the enable off, vblank pending can never become set.
    a_r3_vblank_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !st_pend[0]) |=> !st_pend[0]);

    // R5: fence pending survives every cycle without an explicit clear.
    a_r5_fence_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pend[1] && !fence_clr_wr) |=> st_pend[1]);

    // R7: a fence event always leaves the interrupt raised.
    a_r7_fence_irq: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ack |=> irq);

    // R8: the captured value is the one present at the event.
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ack |=> (fence_q == $past(fence_value)));

    // R9: a command write gives a pulse carrying the written word.
    a_r9_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exec_wr |=> (cmd_stb && cmd_word == $past(bus_wdata)));

    // R9: no pulse without a command write.
    a_r9_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_wr |=> !cmd_stb);

endmodule

bind disp_irq_regs disp_irq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .fence_ack   (fence_ack),
    .fence_value (fence_value),
    .cmd_stb     (cmd_stb),
    .cmd_word    (cmd_word),
    .irq         (irq),
    .ctrl_en     (ctrl_en),
    .st_pend     (st_pend),
    .fence_q     (fence_words)
);

// File: tb/tb_disp_irq_regs.sv
`timescale 1ns/1ps
// Bench for disp_irq_regs: sweeps status states against write values and
// enable settings, and computes every expectation from the requirements.
module tb_disp_irq_regs;

    localparam int AW = 6;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic [DW-1:0]   bus_rdata;
    logic            vblank_tick = 1'b0;
    logic            fence_ack = 1'b0;
    logic [2*DW-1:0] fence_value = '0;
    logic            cmd_stb;
    logic [DW-1:0]   cmd_word;
    logic            irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    disp_irq_regs #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .vblank_tick(vblank_tick),
        .fence_ack(fence_ack), .fence_value(fence_value), .cmd_stb(cmd_stb),
        .cmd_word(cmd_word), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One write; returns just after the following falling edge.
    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; bus_addr = '0;
        #1;
    endtask

    // Combinational read, sampled mid-cycle.
    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    // Event pulses, optionally together with a status write.
    task automatic events(input logic vb, input logic fa, input logic [2*DW-1:0] fv,
                          input logic do_clr, input logic [1:0] clr);
        @(negedge clk);
        vblank_tick = vb; fence_ack = fa; fence_value = fv;
        if (do_clr) begin bus_addr = AW'(16); bus_wdata = DW'(clr); bus_we = 1'b1; end
        @(negedge clk);
        vblank_tick = 1'b0; fence_ack = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [DW-1:0] r;
        logic [2*DW-1:0] fv;
        repeat (3) @(negedge clk);
        // R1: reset state, with reset still held.
        #1 check("R1 irq", DW'(irq), 0);
        check("R1 cmd_stb", DW'(cmd_stb), 0);
        @(negedge clk); rst_n = 1'b1;
        #1 check("R1 irq after release", DW'(irq), 0);
        rd(8, r);  check("R1 ctrl", r, 0);
        rd(16, r); check("R1 status", r, 0);
        rd(24, r); check("R1 fence lo", r, 0);
        rd(32, r); check("R1 fence hi", r, 0);

        // R2: control stores only bit 0.
        foreach (fv[i]) ; // no-op keeps fv declared-use ordering simple
        for (int k = 0; k < 6; k++) begin
            logic [DW-1:0] v;
            v = (k < 4) ? DW'(k) : ((k == 4) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF);
            wr(8, v); rd(8, r);
            check("R2 ctrl readback", r, v & 32'h1);
        end

        // R3: tick with enable off and on.
        for (int en = 0; en < 2; en++) begin
            wr(16, 32'h3); wr(8, DW'(en));
            events(1'b1, 1'b0, '0, 1'b0, 2'b00);
            rd(16, r); check("R3 tick vs enable", r, DW'(en));
            check("R6 irq after tick", DW'(irq), DW'(en));
        end

        // R4/R6: every pending state against every status write, both enables.
        for (int en = 0; en < 2; en++) begin
            for (int init = 0; init < 4; init++) begin
                for (int wv = 0; wv < 4; wv++) begin
                    logic [1:0] exp_st;
                    wr(16, 32'h3); wr(8, 32'h1);
                    events(init[0], init[1], 64'h0, 1'b0, 2'b00);
                    wr(8, DW'(en));
                    rd(16, r); check("R5 status after ctrl write", r, DW'(init[1:0]));
                    wr(16, DW'(wv));
                    exp_st = init[1:0] & ~wv[1:0];
                    rd(16, r); check("R4 w1c result", r, DW'(exp_st));
                    check("R6 irq level", DW'(irq), DW'((exp_st[0] & en[0]) | exp_st[1]));
                end
            end
        end

        // R5: fence pending survives enable toggles.
        wr(16, 32'h3);
        events(1'b0, 1'b1, 64'h0, 1'b0, 2'b00);
        wr(8, 32'h1); wr(8, 32'h0); wr(8, 32'hFFFF_FFFE);
        rd(16, r); check("R5 fence kept", r, 32'h2);
        check("R5 irq kept", DW'(irq), 1);

        // R7: set wins over a same-cycle clear, for both bits.
        wr(16, 32'h3); wr(8, 32'h1);
        events(1'b1, 1'b1, 64'h0, 1'b1, 2'b11);
        rd(16, r); check("R7 set wins", r, 32'h3);

        // R8: fence capture, two values.
        for (int k = 0; k < 2; k++) begin
            fv = (k == 0) ? 64'h1234_5678_9ABC_DEF0 : 64'hFEDC_BA98_7654_3210;
            events(1'b0, 1'b1, fv, 1'b0, 2'b00);
            rd(24, r); check("R8 fence lo", r, fv[31:0]);
            rd(32, r); check("R8 fence hi", r, fv[63:32]);
            rd(16, r); check("R8 fence pending", r & 32'h2, 32'h2);
        end

        // R9: command strobe for one cycle, status untouched.
        wr(16, 32'h3); wr(8, 32'h0);
        @(negedge clk);
        bus_addr = AW'(0); bus_wdata = 32'hA5A5_0F0F; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        #1 check("R9 strobe high", DW'(cmd_stb), 1);
        check("R9 cmd word", cmd_word, 32'hA5A5_0F0F);
        @(negedge clk);
        #1 check("R9 strobe one cycle", DW'(cmd_stb), 0);
        rd(16, r); check("R9 status untouched", r, 0);
        rd(8, r);  check("R9 ctrl untouched", r, 0);

        // R10: unmapped reads and ignored writes.
        rd(0, r);  check("R10 exec reads zero", r, 0);
        rd(4, r);  check("R10 unmapped 4", r, 0);
        rd(40, r); check("R10 unmapped 40", r, 0);
        rd(63, r); check("R10 unmapped 63", r, 0);
        for (int k = 0; k < 4; k++) begin
            int a;
            a = (k == 0) ? 4 : (k == 1) ? 24 : (k == 2) ? 32 : 40;
            @(negedge clk);
            bus_addr = AW'(a); bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1;
            @(negedge clk);
            bus_we = 1'b0;
            #1 check("R10 no strobe", DW'(cmd_stb), 0);
            rd(8, r);  check("R10 ctrl unchanged", r, 0);
            rd(16, r); check("R10 status unchanged", r, 0);
            rd(24, r); check("R10 fence lo unchanged", r, 32'h7654_3210);
        end

        done = 1'b1;
        summary();
    end

endmodule